// File: doc/BRIEF.md
# Effective Address Generator

This unit turns an operand specifier into a memory address. A 4-bit mode code chooses how the address is formed. The inputs it can draw on are a pointer register value, a base register, an index register, the program counter, and an address field from the instruction. The address field is used either whole (16 bits) or as a sign-extended 8-bit displacement. For the post-increment and pre-decrement modes the unit also produces the new value of the pointer register and a write-back enable, using an element size as the step. For the memory-indirect mode it raises a flag that tells the load/store logic a second read is needed to fetch the final address.

All results are registered. The inputs present at a rising clock edge appear on the outputs after that edge, with no handshake. Memory reads and instruction decoding happen outside the unit. An undefined mode code raises an error output and yields address zero, so a bad specifier can never start a write-back.

The control path is a single decode stage. A mode decoder produces an operand-select word, and an address path forms one 16-bit sum from two selected operands. The output register captures the chosen address, the write-back value and the flags.

Top module: `eag_unit`

## Requirements
- R1: Outputs are registered. Values computed from the inputs sampled at a rising edge appear after that edge. While `rst_n` is low, every output is 0.
- R2: Mode 0 (register-indirect): `ea_o` = `reg_val_i`.
- R3: Mode 1 (post-increment): `ea_o` = `reg_val_i`, and `wb_val_o` = `reg_val_i` + `elem_size_i`.
- R4: Mode 2 (pre-decrement): `ea_o` = `wb_val_o` = `reg_val_i` − `elem_size_i`.
- R5: Mode 3 (indexed): `ea_o` = `index_val_i` + displacement.
- R6: Mode 4 (based-indexed): `ea_o` = `base_val_i` + `index_val_i`.
- R7: Mode 5 (PC-relative): `ea_o` = `pc_val_i` + displacement. Mode 6 (base-relative): `ea_o` = `base_val_i` + displacement.
- R8: Mode 7 (direct): `ea_o` = displacement, `indirect_o` = 0. Mode 8 (memory-indirect): `ea_o` = displacement (the pointer word's address) and `indirect_o` = 1. In every other mode `indirect_o` = 0.
- R9: Displacement: when `short_disp_i` = 1 it is `addr_field_i[7:0]` sign-extended from bit 7. When `short_disp_i` = 0 it is the full `addr_field_i`. This applies to modes 3, 5, 6, 7 and 8.
- R10: All sums and differences wrap modulo 2^16.
- R11: `wb_en_o` = 1 only in modes 1 and 2. In all other modes `wb_en_o` = 0 and `wb_val_o` = 0.
- R12: Modes 9 to 15 are undefined. They give `mode_err_o` = 1, `ea_o` = 0, `indirect_o` = 0 and `wb_en_o` = 0. Defined modes give `mode_err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Addressing mode code |
| short_disp_i | input | 1 | 1: use sign-extended 8-bit displacement |
| addr_field_i | input | 16 | Address / displacement field |
| reg_val_i | input | 16 | Named pointer register value |
| base_val_i | input | 16 | Base register value |
| index_val_i | input | 16 | Index register value |
| pc_val_i | input | 16 | Program counter value |
| elem_size_i | input | 4 | Step for post-increment / pre-decrement |
| ea_o | output | 16 | Effective address |
| indirect_o | output | 1 | Second (indirect) memory read needed |
| wb_en_o | output | 1 | Pointer register write-back enable |
| wb_val_o | output | 16 | Pointer register write-back value |
| mode_err_o | output | 1 | Undefined mode code |

## Verification
The bench builds the unit with its default parameters: a 16-bit address, an 8-bit short displacement and a 4-bit step. At these widths every one of the 16 mode codes and both displacement sizes can be swept. Each combination is crossed with operand values at the sign and wrap boundaries (0x0000, 0x7FFF, 0x8000, 0xFFFF and 0x007F/0x0080 fields) and with steps of 0, 1, 2, 8 and 15. This reaches both carry-out and borrow wrap, and sign extension of both polarities.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MD_REG_IND   = 4'd0,
        MD_POST_INC  = 4'd1,
        MD_PRE_DEC   = 4'd2,
        MD_INDEXED   = 4'd3,
        MD_BASE_IDX  = 4'd4,
        MD_PC_REL    = 4'd5,
        MD_BASE_REL  = 4'd6,
        MD_DIRECT    = 4'd7,
        MD_MEM_IND   = 4'd8
    } mode_e;

    typedef enum logic [2:0] {
        OPA_ZERO,
        OPA_PTR,
        OPA_BASE,
        OPA_INDEX,
        OPA_PC
    } opa_sel_e;

    typedef enum logic [2:0] {
        OPB_ZERO,
        OPB_DISP,
        OPB_INDEX,
        OPB_STEP_UP,
        OPB_STEP_DOWN
    } opb_sel_e;

    typedef enum logic [1:0] {
        EA_SUM,
        EA_OPA,
        EA_ZERO
    } ea_sel_e;

    typedef struct packed {
        opa_sel_e opa;
        opb_sel_e opb;
        ea_sel_e  ea_sel;
        logic     wb_en;
        logic     indirect;
        logic     err;
    } ea_ctl_t;

endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
    parameter int AW     = 16,
    parameter int SHORTW = 8
) (
    input  logic [AW-1:0] field_i,
    input  logic          short_i,
    output logic [AW-1:0] disp_o
);
    localparam int PADW = AW - SHORTW;

    logic [AW-1:0] short_ext;

    generate
        if (PADW > 0) begin : g_pad
            assign short_ext = {{PADW{field_i[SHORTW-1]}}, field_i[SHORTW-1:0]};
        end else begin : g_nopad
            assign short_ext = field_i;
        end
    endgenerate

    assign disp_o = short_i ? short_ext : field_i;

endmodule

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
    import ea_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output ea_ctl_t           ctl_o
);
    always_comb begin
        ctl_o = '{opa: OPA_ZERO, opb: OPB_ZERO, ea_sel: EA_ZERO,
                  wb_en: 1'b0, indirect: 1'b0, err: 1'b0};
        unique case (mode_i)
            MD_REG_IND: begin
                ctl_o.opa    = OPA_PTR;
                ctl_o.ea_sel = EA_OPA;
            end
            MD_POST_INC: begin
                ctl_o.opa    = OPA_PTR;
                ctl_o.opb    = OPB_STEP_UP;
                ctl_o.ea_sel = EA_OPA;
                ctl_o.wb_en  = 1'b1;
            end
            MD_PRE_DEC: begin
                ctl_o.opa    = OPA_PTR;
                ctl_o.opb    = OPB_STEP_DOWN;
                ctl_o.ea_sel = EA_SUM;
                ctl_o.wb_en  = 1'b1;
            end
            MD_INDEXED: begin
                ctl_o.opa    = OPA_INDEX;
                ctl_o.opb    = OPB_DISP;
                ctl_o.ea_sel = EA_SUM;
            end
            MD_BASE_IDX: begin
                ctl_o.opa    = OPA_BASE;
                ctl_o.opb    = OPB_INDEX;
                ctl_o.ea_sel = EA_SUM;
            end
            MD_PC_REL: begin
                ctl_o.opa    = OPA_PC;
                ctl_o.opb    = OPB_DISP;
                ctl_o.ea_sel = EA_SUM;
            end
            MD_BASE_REL: begin
                ctl_o.opa    = OPA_BASE;
                ctl_o.opb    = OPB_DISP;
                ctl_o.ea_sel = EA_SUM;
            end
            MD_DIRECT: begin
                ctl_o.opb    = OPB_DISP;
                ctl_o.ea_sel = EA_SUM;
            end
            MD_MEM_IND: begin
                ctl_o.opb      = OPB_DISP;
                ctl_o.ea_sel   = EA_SUM;
                ctl_o.indirect = 1'b1;
            end
            default: begin
                ctl_o.err = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ea_addr_path.sv
module ea_addr_path
    import ea_pkg::*;
#(
    parameter int AW  = 16,
    parameter int SZW = 4
) (
    input  opa_sel_e       opa_sel_i,
    input  opb_sel_e       opb_sel_i,
    input  logic [AW-1:0]  ptr_i,
    input  logic [AW-1:0]  base_i,
    input  logic [AW-1:0]  index_i,
    input  logic [AW-1:0]  pc_i,
    input  logic [AW-1:0]  disp_i,
    input  logic [SZW-1:0] step_i,
    output logic [AW-1:0]  opa_o,
    output logic [AW-1:0]  sum_o
);
    logic [AW-1:0] step_ext;
    logic [AW-1:0] opb;

    assign step_ext = AW'(step_i);

    always_comb begin
        unique case (opa_sel_i)
            OPA_PTR:   opa_o = ptr_i;
            OPA_BASE:  opa_o = base_i;
            OPA_INDEX: opa_o = index_i;
            OPA_PC:    opa_o = pc_i;
            default:   opa_o = '0;
        endcase
    end

    always_comb begin
        unique case (opb_sel_i)
            OPB_DISP:      opb = disp_i;
            OPB_INDEX:     opb = index_i;
            OPB_STEP_UP:   opb = step_ext;
            OPB_STEP_DOWN: opb = (~step_ext) + AW'(1);
            default:       opb = '0;
        endcase
    end

    // Single adder; the carry out is dropped so results wrap modulo 2^AW.
    assign sum_o = opa_o + opb;

endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import ea_pkg::*;
#(
    parameter int AW     = 16,
    parameter int SHORTW = 8,
    parameter int SZW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              short_disp_i,
    input  logic [AW-1:0]     addr_field_i,
    input  logic [AW-1:0]     reg_val_i,
    input  logic [AW-1:0]     base_val_i,
    input  logic [AW-1:0]     index_val_i,
    input  logic [AW-1:0]     pc_val_i,
    input  logic [SZW-1:0]    elem_size_i,
    output logic [AW-1:0]     ea_o,
    output logic              indirect_o,
    output logic              wb_en_o,
    output logic [AW-1:0]     wb_val_o,
    output logic              mode_err_o
);
    ea_ctl_t       ctl;
    logic [AW-1:0] disp;
    logic [AW-1:0] opa;
    logic [AW-1:0] sum;
    logic [AW-1:0] ea_next;
    logic [AW-1:0] wb_next;
    logic          seen_q;

    ea_mode_decode u_decode (
        .mode_i (mode_i),
        .ctl_o  (ctl)
    );

    ea_disp_ext #(.AW(AW), .SHORTW(SHORTW)) u_disp (
        .field_i (addr_field_i),
        .short_i (short_disp_i),
        .disp_o  (disp)
    );

    ea_addr_path #(.AW(AW), .SZW(SZW)) u_path (
        .opa_sel_i (ctl.opa),
        .opb_sel_i (ctl.opb),
        .ptr_i     (reg_val_i),
        .base_i    (base_val_i),
        .index_i   (index_val_i),
        .pc_i      (pc_val_i),
        .disp_i    (disp),
        .step_i    (elem_size_i),
        .opa_o     (opa),
        .sum_o     (sum)
    );

    always_comb begin
        unique case (ctl.ea_sel)
            EA_SUM:  ea_next = sum;
            EA_OPA:  ea_next = opa;
            default: ea_next = '0;
        endcase
        wb_next = ctl.wb_en ? sum : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_o       <= '0;
            indirect_o <= 1'b0;
            wb_en_o    <= 1'b0;
            wb_val_o   <= '0;
            mode_err_o <= 1'b0;
            seen_q     <= 1'b0;
        end else begin
            ea_o       <= ea_next;
            indirect_o <= ctl.indirect;
            wb_en_o    <= ctl.wb_en;
            wb_val_o   <= wb_next;
            mode_err_o <= ctl.err;
            seen_q     <= 1'b1;
        end
    end

    AST_ERR_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> (ea_o == '0 && !wb_en_o && !indirect_o)); // R12
    AST_WB_NOT_WITH_IND: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (!mode_err_o && !indirect_o)); // R11
    AST_IND_ONLY_MEMIND: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && indirect_o) |-> ($past(mode_i) == MD_MEM_IND)); // R8
    AST_POSTINC_EA_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(mode_i) == MD_POST_INC) |-> (ea_o == $past(reg_val_i) && wb_en_o)); // R3
    AST_PREDEC_EA_EQ_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(mode_i) == MD_PRE_DEC) |-> (ea_o == wb_val_o && wb_en_o)); // R4
    AST_REGIND_EA_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(mode_i) == MD_REG_IND) |-> (ea_o == $past(reg_val_i) && !wb_en_o)); // R2

endmodule

// File: tb/test_eag_unit.sv
module test_eag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode_i = '0;
    logic        short_disp_i = 1'b0;
    logic [15:0] addr_field_i = '0;
    logic [15:0] reg_val_i = '0, base_val_i = '0, index_val_i = '0, pc_val_i = '0;
    logic [3:0]  elem_size_i = '0;
    logic [15:0] ea_o, wb_val_o;
    logic        indirect_o, wb_en_o, mode_err_o;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    eag_unit i_eag_unit (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .short_disp_i(short_disp_i),
        .addr_field_i(addr_field_i), .reg_val_i(reg_val_i), .base_val_i(base_val_i),
        .index_val_i(index_val_i), .pc_val_i(pc_val_i), .elem_size_i(elem_size_i),
        .ea_o(ea_o), .indirect_o(indirect_o), .wb_en_o(wb_en_o),
        .wb_val_o(wb_val_o), .mode_err_o(mode_err_o)
    );

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5, 4'd6: return "R7";
            4'd7, 4'd8: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] ea, input logic ind,
                         input logic wen, input logic [15:0] wv, input logic err);
        n_vec++;
        if (ea_o !== ea || indirect_o !== ind || wb_en_o !== wen ||
            wb_val_o !== wv || mode_err_o !== err) begin
            n_bad++;
            $display("FAIL %s: got ea=%h ind=%b wen=%b wb=%h err=%b, expected ea=%h ind=%b wen=%b wb=%h err=%b",
                     req, ea_o, indirect_o, wb_en_o, wb_val_o, mode_err_o, ea, ind, wen, wv, err);
        end
    endtask

    initial begin
        logic [15:0] vals [6];
        logic [15:0] flds [6];
        logic [3:0]  steps [5];
        vals  = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234, 16'h00FF};
        flds  = '{16'h0080, 16'h007F, 16'hFF80, 16'h1234, 16'h0000, 16'hFFFF};
        steps = '{4'd0, 4'd1, 4'd2, 4'd8, 4'd15};

        repeat (3) @(negedge clk);
        check("R1 reset", 16'h0, 1'b0, 1'b0, 16'h0, 1'b0);
        rst_n = 1'b1;

        for (int m = 0; m < 16; m++) begin
            for (int sd = 0; sd < 2; sd++) begin
                for (int k = 0; k < 6; k++) begin
                    for (int s = 0; s < 5; s++) begin
                        logic [15:0] r, b, x, p, f, d, st, eae, wbe;
                        logic ine, wne, ere;
                        r = vals[k]; b = vals[(k+1)%6]; x = vals[(k+3)%6];
                        p = vals[(k+5)%6]; f = flds[(k+s)%6]; st = {12'h0, steps[s]};
                        @(negedge clk);
                        mode_i = m[3:0]; short_disp_i = sd[0]; addr_field_i = f;
                        reg_val_i = r; base_val_i = b; index_val_i = x; pc_val_i = p;
                        elem_size_i = steps[s];
                        // R9: short displacement is field[7:0] sign-extended
                        d = sd[0] ? {{8{f[7]}}, f[7:0]} : f;
                        eae = 16'h0; wbe = 16'h0; ine = 1'b0; wne = 1'b0; ere = 1'b0;
                        case (m)
                            0: eae = r;
                            1: begin eae = r; wbe = 16'((32'(r) + 32'(st)) % 65536); wne = 1'b1; end
                            2: begin eae = 16'((32'(r) + 65536 - 32'(st)) % 65536); wbe = eae; wne = 1'b1; end
                            3: eae = 16'((32'(x) + 32'(d)) % 65536);
                            4: eae = 16'((32'(b) + 32'(x)) % 65536);
                            5: eae = 16'((32'(p) + 32'(d)) % 65536);
                            6: eae = 16'((32'(b) + 32'(d)) % 65536);
                            7: eae = d;
                            8: begin eae = d; ine = 1'b1; end
                            default: ere = 1'b1;
                        endcase
                        @(negedge clk);
                        check($sformatf("%s/R1/R9/R10/R11 mode=%0d short=%0d", tag_of(m[3:0]), m, sd),
                              eae, ine, wne, wbe, ere);
                    end
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule